// File: doc/BRIEF.md
# Physical Register Free List

This block keeps the pool of unused physical register numbers for the rename stage of an out-of-order core. It is a circular queue. Each cycle the rename stage reads a group of registers from the head, one per lane that asks for one. Retirement writes released registers back at the tail, again one per lane that offers one. The queue holds `NUM_PHYS - NUM_ARCH` entries, and that count must be a power of two.

Misprediction recovery keeps no per-branch snapshot. While the reorder buffer replays discarded instructions youngest first, the rename stage passes in how many of them had a destination register, and the head moves back by that number. The registers those instructions took are therefore the next ones handed out. A flush puts the head at the position where every register outside the committed mapping is free again.

At reset the architectural registers map one-to-one onto physical registers `0` to `NUM_ARCH-1`, so the queue holds `NUM_ARCH` to `NUM_PHYS-1` in ascending order.

Top module: `freelist`

## Requirements
- R1: After reset the free count is `NUM_PHYS-NUM_ARCH`. The first registers handed out are `NUM_ARCH`, `NUM_ARCH+1`, and so on, in ascending order.
- R2: Within a group, lane `i` carries `alloc_req` bit `i` and its index is on `alloc_idx[i*IW +: IW]`. Lanes that request take consecutive queue entries from the head, in ascending lane order, and lanes that do not request are skipped. A non-requesting lane outputs zero.
- R3: `can_alloc` is high exactly when the free count is at least the number of set `alloc_req` bits. A group is served completely or not at all.
- R4: The head advances by the number of requests only in a cycle where `alloc_go` and `can_alloc` are high and `walk`, `flush` and `redirect` are low. In any other cycle the same registers are offered again.
- R5: Outside walk, each set `free_req` bit `j` appends `free_idx[j*IW +: IW]` at the tail in ascending lane order. These registers are handed out only after every register that was already free.
- R6: While `walk` is high, free requests are ignored.
- R7: While `walk` is high, the head moves back by `step_back`. The registers returned this way are reissued next, in their original order.
- R8: No register is handed out in a cycle where `walk` is high, even with `alloc_go` high.
- R9: After `flush` the free count is `NUM_PHYS-NUM_ARCH`. Flush takes priority over walk and allocation. Free requests in the same cycle are still accepted.
- R10: `redirect` blocks allocation in its cycle and changes nothing else.
- R11: No register is handed out a second time before it is freed, walked back or flushed.
- R12: The free count never exceeds the queue depth. The wrap bit of the pointers tells a full queue from an empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_req | input | ALLOC_W | Per-lane request for a new register |
| alloc_go | input | 1 | External permission to consume the group |
| can_alloc | output | 1 | Enough free entries for the whole group |
| alloc_idx | output | ALLOC_W*IW | Per-lane register offered to the lane |
| free_req | input | FREE_W | Per-lane release of a register |
| free_idx | input | FREE_W*IW | Per-lane register being released |
| flush | input | 1 | Abandon all speculative allocations |
| redirect | input | 1 | Block allocation this cycle |
| walk | input | 1 | Recovery replay in progress |
| step_back | input | $clog2(FREE_W+1) | Entries to rewind while walking |

## Verification
The hardest state to reach from the ports is a rewind across the wrap point while the queue is nearly empty. This requires heavy allocation and few releases, followed by a walk of several entries. The random stimulus alternates 300-cycle stretches of normal release rate with stretches where releases are rare, so the queue repeatedly drains to empty and the pointers wrap. Walks, flushes and redirects are scattered through both kinds of stretch. A bench-side record of outstanding registers, oldest at the front and youngest at the back, supplies valid release and rewind amounts and detects any register issued twice.

// File: rtl/freelist.sv
module freelist #(
  parameter int NUM_PHYS = 64,
  parameter int NUM_ARCH = 32,
  parameter int ALLOC_W  = 4,
  parameter int FREE_W   = 4,
  localparam int DEPTH = NUM_PHYS - NUM_ARCH,
  localparam int PW    = $clog2(DEPTH),
  localparam int IW    = $clog2(NUM_PHYS),
  localparam int AC    = $clog2(ALLOC_W + 1),
  localparam int FC    = $clog2(FREE_W + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ALLOC_W-1:0]    alloc_req,
  input  logic                  alloc_go,
  output logic                  can_alloc,
  output logic [ALLOC_W*IW-1:0] alloc_idx,
  input  logic [FREE_W-1:0]     free_req,
  input  logic [FREE_W*IW-1:0]  free_idx,
  input  logic                  flush,
  input  logic                  redirect,
  input  logic                  walk,
  input  logic [FC-1:0]         step_back
);

  logic [IW-1:0] ring [DEPTH];
  logic [PW:0]   head, tail, head_nx, tail_nx, count;
  logic [AC-1:0] a_off [ALLOC_W];
  logic [FC-1:0] f_off [FREE_W];
  logic [AC-1:0] need;
  logic [FC-1:0] nfree;
  logic          fire, take_free;

  always_comb begin
    need = '0;
    for (int i = 0; i < ALLOC_W; i++) begin
      a_off[i] = need;
      need = need + AC'(alloc_req[i]);
    end
    nfree = '0;
    for (int j = 0; j < FREE_W; j++) begin
      f_off[j] = nfree;
      nfree = nfree + FC'(free_req[j]);
    end
  end

  assign count     = tail - head;
  assign can_alloc = count >= (PW+1)'(need);
  assign fire      = alloc_go & can_alloc & ~walk & ~flush & ~redirect;
  assign take_free = ~walk;

  for (genvar g = 0; g < ALLOC_W; g++) begin : g_lane
    logic [PW:0] slot;
    assign slot = head + (PW+1)'(a_off[g]);
    assign alloc_idx[g*IW +: IW] = alloc_req[g] ? ring[slot[PW-1:0]] : '0;
  end

  assign tail_nx = take_free ? tail + (PW+1)'(nfree) : tail;

  always_comb begin
    if (flush)     head_nx = tail_nx - (PW+1)'(DEPTH);
    else if (walk) head_nx = head - (PW+1)'(step_back);
    else if (fire) head_nx = head + (PW+1)'(need);
    else           head_nx = head;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= (PW+1)'(DEPTH);
      for (int k = 0; k < DEPTH; k++) ring[k] <= IW'(NUM_ARCH + k);
    end else begin
      head <= head_nx;
      tail <= tail_nx;
      for (int j = 0; j < FREE_W; j++) begin
        logic [PW:0] ws;
        ws = tail + (PW+1)'(f_off[j]);
        if (take_free && free_req[j]) ring[ws[PW-1:0]] <= free_idx[j*IW +: IW];
      end
    end
  end

endmodule

module freelist_chk #(
  parameter int DEPTH = 32,
  parameter int PW    = 5,
  parameter int FC    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          alloc_go,
  input logic          can_alloc,
  input logic          walk,
  input logic          flush,
  input logic          redirect,
  input logic [FC-1:0] step_back,
  input logic [PW:0]   head,
  input logic [PW:0]   tail
);

  assert_count_bounded_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tail - head) <= (PW+1)'(DEPTH));

  assert_walk_rewind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (walk && !flush) |=> head == $past(head) - (PW+1)'($past(step_back)));

  assert_walk_ignores_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    walk |=> $stable(tail));

  assert_gate_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !walk && !alloc_go) |=> $stable(head));

  assert_redirect_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect && !flush && !walk) |=> $stable(head));

  assert_flush_refill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail - head) == (PW+1)'(DEPTH));

  assert_alloc_within_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_go && can_alloc && !walk && !flush && !redirect)
      |=> (head - $past(head)) <= $past(tail - head));

endmodule

bind freelist freelist_chk #(.DEPTH(DEPTH), .PW(PW), .FC(FC)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_go(alloc_go), .can_alloc(can_alloc),
  .walk(walk), .flush(flush), .redirect(redirect), .step_back(step_back),
  .head(head), .tail(tail)
);

// File: tb/freelist_tb.sv
`timescale 1ns/1ps
module freelist_tb;
  localparam int NP = 64, NA = 32, AW = 4, FW = 4;
  localparam int D  = NP - NA;
  localparam int IW = $clog2(NP);
  localparam int FC = $clog2(FW + 1);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] alloc_req = '0;
  logic alloc_go = 0, can_alloc;
  logic [AW*IW-1:0] alloc_idx;
  logic [FW-1:0] free_req = '0;
  logic [FW*IW-1:0] free_idx = '0;
  logic flush = 0, redirect = 0, walk = 0;
  logic [FC-1:0] step_back = '0;

  freelist #(.NUM_PHYS(NP), .NUM_ARCH(NA), .ALLOC_W(AW), .FREE_W(FW)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_go(alloc_go),
    .can_alloc(can_alloc), .alloc_idx(alloc_idx), .free_req(free_req),
    .free_idx(free_idx), .flush(flush), .redirect(redirect), .walk(walk),
    .step_back(step_back));

  always #2 clk = ~clk;

  int compared = 0, mismatched = 0;
  int ring_m [D];
  int hd, tl;
  bit owned [NP];
  int rob [$];
  string cur_tag = "R1";
  bit done = 0;

  task automatic chk(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [AW-1:0] req, bit go, int nf, bit fl, bit rd, bit wk, int sb);
    int need, p, v;
    bit expc, fire;
    @(negedge clk);
    alloc_req = req; alloc_go = go; flush = fl; redirect = rd; walk = wk;
    step_back = FC'(sb);
    free_req = '0; free_idx = '0;
    for (int j = 0; j < nf; j++) begin
      free_req[j] = 1'b1;
      free_idx[j*IW +: IW] = IW'(rob[j]);
    end
    #1;
    need = $countones(req);
    expc = (tl - hd) >= need;
    chk(cur_tag, "can_alloc", int'(can_alloc), int'(expc));
    if (expc) begin
      p = 0;
      for (int i = 0; i < AW; i++)
        if (req[i]) begin
          chk(cur_tag, $sformatf("lane%0d index", i), int'(alloc_idx[i*IW +: IW]), ring_m[(hd + p) & (D-1)]);
          p++;
        end
    end
    fire = go && expc && !wk && !fl && !rd;
    if (!wk) begin
      for (int j = 0; j < nf; j++) begin
        v = rob.pop_front();
        ring_m[(tl + j) & (D-1)] = v;
        owned[v] = 0;
      end
      tl += nf;
    end
    if (fl) begin
      foreach (rob[k]) owned[rob[k]] = 0;
      rob.delete();
      hd = tl - D;
    end else if (wk) begin
      for (int k = 0; k < sb; k++) begin
        v = rob.pop_back();
        owned[v] = 0;
      end
      hd -= sb;
    end else if (fire) begin
      for (int i = 0; i < AW; i++)
        if (req[i]) begin
          v = int'(alloc_idx[i*IW +: IW]);
          chk("R11", "already outstanding", int'(owned[v]), 0);
          owned[v] = 1;
          rob.push_back(v);
        end
      hd += need;
    end
  endtask

  function automatic int min2(int a, int b);
    return a < b ? a : b;
  endfunction

  initial begin
    #(4 * 200000);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    for (int k = 0; k < D; k++) ring_m[k] = NA + k;
    hd = 0; tl = D;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    alloc_req = 4'hF;
    #1;
    chk("R1", "can_alloc after reset", int'(can_alloc), 1);
    for (int i = 0; i < AW; i++)
      chk("R1", "first index", int'(alloc_idx[i*IW +: IW]), NA + i);

    cur_tag = "R4"; step(4'hF, 0, 0, 0, 0, 0, 0); step(4'hF, 0, 0, 0, 0, 0, 0);
    cur_tag = "R2"; step(4'b1010, 1, 0, 0, 0, 0, 0); step(4'b0110, 1, 0, 0, 0, 0, 0);
    step(4'b0001, 1, 0, 0, 0, 0, 0);
    cur_tag = "R10"; step(4'hF, 1, 0, 0, 1, 0, 0); step(4'hF, 0, 0, 0, 0, 0, 0);
    cur_tag = "R8"; step(4'hF, 1, 0, 0, 0, 1, 2);
    cur_tag = "R7"; step(4'b0011, 1, 0, 0, 0, 0, 0); step(4'hF, 0, 0, 0, 0, 0, 0);
    cur_tag = "R6"; step(4'h0, 0, 2, 0, 0, 1, 0);
    cur_tag = "R5"; step(4'h0, 0, 2, 0, 0, 0, 0);
    cur_tag = "R3";
    for (int n = 0; n < 10; n++) step(4'hF, 1, 0, 0, 0, 0, 0);
    step(4'h0, 1, 0, 0, 0, 0, 0); step(4'b0001, 1, 0, 0, 0, 0, 0);
    cur_tag = "R5"; step(4'h0, 0, 3, 0, 0, 0, 0); step(4'b0111, 1, 0, 0, 0, 0, 0);
    cur_tag = "R9"; step(4'hF, 1, 0, 1, 0, 1, 1);
    cur_tag = "R12"; step(4'hF, 0, 0, 0, 0, 0, 0);

    cur_tag = "R3";
    for (int c = 0; c < 3000; c++) begin
      int r, nf, sb;
      bit fl, wk, rd;
      r  = int'($urandom % 100);
      fl = r < 2;
      wk = !fl && r < 14 && rob.size() > 0;
      rd = r >= 14 && r < 18;
      sb = wk ? int'($urandom % (min2(4, rob.size()) + 1)) : 0;
      nf = int'($urandom % (min2(FW, rob.size()) + 1));
      if (((c / 300) % 2) == 1 && ($urandom % 4) != 0) nf = 0;
      step(AW'($urandom), ($urandom % 8) != 0, nf, fl, rd, wk, sb);
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule